// File: doc/BRIEF.md
# Serially Programmed Clock Fanout Controller

This block sets which of two source clocks is fanned out to ten output lanes, and which of those lanes carry the clock. A three-wire control port sets it up: a programming enable, a serial data line and a programming clock. All three are brought into the block's own logic clock domain by two-stage synchronizers. Rising edges are found there by comparing successive synchronized samples.

While the enable is high, each rising programming-clock edge shifts one serial bit into an 11-bit frame. A pulse counter follows these edges. Its twelfth edge copies the frame into a control register, and that register sets the per-lane enables and the source choice. Later edges are ignored until the enable rises again. A rising enable clears the frame, the counter and the control register. While the enable is low, the control register is bypassed: every lane is on, and the serial data line picks the source directly.

A disabled lane drives its clock output low and clears its own output-enable flag.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset with the enable low and serial data low, all ten output-enable flags are 1 and every lane follows source clock 0.
- R2: While the enable is high, each rising programming-clock edge shifts in one serial bit. The first bit of a frame is the enable for lane 9, the next is for lane 8, and so on down to lane 0 in the tenth position. The eleventh bit selects the source.
- R3: An enable bit of 1 turns its lane on and 0 turns it off. A select bit of 0 picks source clock 0 and 1 picks source clock 1.
- R4: The control register changes only on the twelfth rising programming-clock edge after the enable rose. Until that edge, with the enable high, every lane is off.
- R5: A rising edge on the enable clears the frame, the pulse counter and the control register, so a partial frame is discarded.
- R6: Programming-clock edges after the twelfth leave the control register unchanged until the next rising enable. The pulse counter never goes beyond 12.
- R7: While the enable is low, the control register has no effect. All lanes are on, and the synchronized serial data level picks the source (0 for clock 0, 1 for clock 1).
- R8: While the enable is high, each enabled lane outputs the source chosen by the control register. Each disabled lane outputs 0 with its enable flag 0. A change on the control inputs reaches the outputs two logic-clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src0_clk_i | input | 1 | Source clock 0 |
| src1_clk_i | input | 1 | Source clock 1 |
| prog_en_i | input | 1 | Programming enable, asynchronous |
| prog_data_i | input | 1 | Serial programming data, asynchronous |
| prog_clk_i | input | 1 | Programming clock, asynchronous |
| clk_o | output | 10 | Gated lane clocks, low when a lane is off |
| oe_o | output | 10 | Per-lane output-enable flags |

## Verification
The assertions assume two things about the control inputs. Each level is held for at least two logic-clock cycles, so the synchronizers never miss a programming-clock pulse. A programming-clock edge never falls in the same synchronized cycle as a rising enable. The stimulus holds every control level for three logic cycles and keeps the programming clock low around each enable change. Source clocks are driven as slow square waves, a quarter period after the logic-clock edge, so the lane gating is sampled at stable levels.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;
  typedef enum logic {SRC_0 = 1'b0, SRC_1 = 1'b1} src_sel_e;
endpackage

// File: rtl/cfo_sync.sv
module cfo_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfo_loader.sv
module cfo_loader
  import clk_fanout_pkg::*;
#(
  parameter int NUM_OUT = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               ck_i,
  input  logic               si_i,
  output logic [NUM_OUT-1:0] lane_en_o,
  output src_sel_e           sel_o
);
  localparam int FRAME = NUM_OUT + 1;
  localparam int DONE  = FRAME + 1;
  localparam int CW    = $clog2(DONE + 1);

  logic             en_d_q, ck_d_q;
  logic [FRAME-1:0] shift_q, ctrl_q;
  logic [CW-1:0]    cnt_q;
  logic             en_rise, ck_rise, step;

  assign en_rise = en_i & ~en_d_q;
  assign ck_rise = ck_i & ~ck_d_q;
  assign step    = en_i & ck_rise & ~en_rise & (cnt_q != CW'(DONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q  <= 1'b0;
      ck_d_q  <= 1'b0;
      shift_q <= '0;
      ctrl_q  <= '0;
      cnt_q   <= '0;
    end else begin
      en_d_q <= en_i;
      ck_d_q <= ck_i;
      if (en_rise) begin
        shift_q <= '0;
        ctrl_q  <= '0;
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CW'(FRAME)) shift_q <= {shift_q[FRAME-2:0], si_i};
        else                    ctrl_q  <= shift_q;
      end
    end
  end

  // first bit lands in the top stage: lane k enable sits at stage k+1
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_map
    assign lane_en_o[k] = ctrl_q[k+1];
  end
  assign sel_o = src_sel_e'(ctrl_q[0]);

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (cnt_q < CW'(FRAME))) |=> (shift_q[0] == $past(si_i)));
  assert_load_only_12th_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> (($past(cnt_q) == CW'(FRAME)) || (ctrl_q == '0)));
  assert_clear_on_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> ((ctrl_q == '0) && (cnt_q == '0) && (shift_q == '0)));
  assert_hold_after_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == CW'(DONE)) && !en_rise) |=> $stable(ctrl_q));
  assert_cnt_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DONE));
endmodule

// File: rtl/cfo_mux.sv
module cfo_mux
  import clk_fanout_pkg::*;
#(
  parameter int NUM_OUT = 10
) (
  input  logic               en_i,
  input  logic               si_i,
  input  logic [NUM_OUT-1:0] lane_en_i,
  input  src_sel_e           sel_i,
  input  logic               src0_i,
  input  logic               src1_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] oe_o
);
  src_sel_e eff_sel;
  logic     src_clk;

  assign eff_sel = en_i ? sel_i : src_sel_e'(si_i);
  assign src_clk = (eff_sel == SRC_1) ? src1_i : src0_i;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    assign oe_o[k]  = en_i ? lane_en_i[k] : 1'b1;
    assign clk_o[k] = oe_o[k] & src_clk;
  end
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import clk_fanout_pkg::*;
#(
  parameter int NUM_OUT     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src0_clk_i,
  input  logic               src1_clk_i,
  input  logic               prog_en_i,
  input  logic               prog_data_i,
  input  logic               prog_clk_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] oe_o
);
  logic [2:0]         ctl_s;
  logic [NUM_OUT-1:0] lane_en;
  src_sel_e           sel;

  cfo_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({prog_en_i, prog_clk_i, prog_data_i}),
    .q_o   (ctl_s)
  );

  cfo_loader #(.NUM_OUT(NUM_OUT)) u_loader (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctl_s[2]),
    .ck_i     (ctl_s[1]),
    .si_i     (ctl_s[0]),
    .lane_en_o(lane_en),
    .sel_o    (sel)
  );

  cfo_mux #(.NUM_OUT(NUM_OUT)) u_mux (
    .en_i     (ctl_s[2]),
    .si_i     (ctl_s[0]),
    .lane_en_i(lane_en),
    .sel_i    (sel),
    .src0_i   (src0_clk_i),
    .src1_i   (src1_clk_i),
    .clk_o    (clk_o),
    .oe_o     (oe_o)
  );

  assert_bypass_all_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_s[2] |-> (oe_o == '1));
  assert_gated_from_ctrl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_s[2] |-> (oe_o == lane_en));
endmodule

// File: tb/clk_fanout_ctrl_test.sv
`timescale 1ns/1ps
module clk_fanout_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic src0 = 1'b0, src1 = 1'b0, en = 1'b0, si = 1'b0, ck = 1'b0;
  logic [9:0] clk_o, oe_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_fanout_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src0_clk_i(src0), .src1_clk_i(src1),
    .prog_en_i(en), .prog_data_i(si), .prog_clk_i(ck), .clk_o(clk_o), .oe_o(oe_o)
  );

  // behavioural reference: history of sampled control inputs
  int h_en[3], h_ck[3], h_si[3];
  bit fq[$];
  int m_cnt;
  logic [9:0] m_oe;
  int m_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin h_en[i] = 0; h_ck[i] = 0; h_si[i] = 0; end
      fq.delete(); m_cnt = 0; m_oe = '0; m_sel = 0;
    end else begin
      if (h_en[1] == 1 && h_en[2] == 0) begin
        fq.delete(); m_cnt = 0; m_oe = '0; m_sel = 0;
      end else if (h_en[1] == 1 && h_ck[1] == 1 && h_ck[2] == 0 && m_cnt < 12) begin
        if (m_cnt < 11) fq.push_back(h_si[1] != 0);
        else begin
          for (int i = 0; i < 10; i++) m_oe[9-i] = fq[i];
          m_sel = fq[10] ? 1 : 0;
        end
        m_cnt++;
      end
      for (int i = 2; i > 0; i--) begin h_en[i] = h_en[i-1]; h_ck[i] = h_ck[i-1]; h_si[i] = h_si[i-1]; end
      h_en[0] = en; h_ck[0] = ck; h_si[0] = si;
    end
  end

  task automatic check_vec(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [9:0] e_oe, e_clk;
      int sel;
      logic s;
      e_oe = h_en[1] ? m_oe : 10'h3ff;
      sel  = h_en[1] ? m_sel : h_si[1];
      s    = sel ? src1 : src0;
      e_clk = e_oe & {10{s}};
      check_vec(h_en[1] ? "R8 oe" : "R7 oe", oe_o, e_oe);
      check_vec(h_en[1] ? "R8 clk" : "R7 clk", clk_o, e_clk);
    end
  end

  initial begin : src_gen
    int n = 0;
    forever begin
      @(posedge clk); #5;
      n++;
      if (n % 3 == 0) src0 = ~src0;
      if (n % 5 == 0) src1 = ~src1;
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic pulse(logic b);
    si = b; tick(3); ck = 1'b1; tick(3); ck = 1'b0; tick(3);
  endtask

  // sends lane enables Q9 first down to Q0, then the select bit
  task automatic send_frame(logic [9:0] lanes, logic sel, int pulses);
    for (int i = 0; i < pulses; i++) begin
      if (i < 10) pulse(lanes[9-i]);
      else if (i == 10) pulse(sel);
      else pulse(1'b0);
    end
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    at_neg(); check_vec("R1 reset oe", oe_o, 10'h3ff);
    check_vec("R1 reset clk", clk_o, {10{src0}});

    // R7: bypass, SI picks source 1
    si = 1'b1; tick(6);
    at_neg(); check_vec("R7 bypass src1", clk_o, {10{src1}});
    si = 1'b0; tick(3);

    // R4: before twelfth edge lanes are off
    en = 1'b1; tick(4);
    send_frame(10'b1010011100, 1'b1, 11);
    at_neg(); check_vec("R4 pre-load off", oe_o, 10'h000);
    send_frame(10'b0, 1'b0, 0);
    pulse(1'b0);
    at_neg(); check_vec("R2 R3 loaded lanes", oe_o, 10'b1010011100);
    check_vec("R3 select src1", clk_o, 10'b1010011100 & {10{src1}});

    // R6: extra edges ignored
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    at_neg(); check_vec("R6 extra edges", oe_o, 10'b1010011100);
    tick(20);

    // R7: EN low overrides control register
    en = 1'b0; si = 1'b0; tick(4);
    at_neg(); check_vec("R7 all on", oe_o, 10'h3ff);
    check_vec("R7 src0", clk_o, {10{src0}});

    // R5: EN rise clears
    en = 1'b1; tick(4);
    at_neg(); check_vec("R5 cleared", oe_o, 10'h000);

    // R5: partial frame discarded, then new full frame with select 0
    send_frame(10'b1111111111, 1'b1, 6);
    en = 1'b0; tick(4); en = 1'b1; tick(4);
    send_frame(10'b0000000001, 1'b0, 12);
    at_neg(); check_vec("R5 R2 lane0 only", oe_o, 10'b0000000001);
    check_vec("R3 select src0", clk_o, {9'b0, src0});

    send_frame(10'b1000000000, 1'b1, 0);
    en = 1'b0; tick(4); en = 1'b1; tick(4);
    send_frame(10'b1000000000, 1'b1, 12);
    at_neg(); check_vec("R2 lane9 first bit", oe_o, 10'b1000000000);
    tick(40);
    finish_run();
  end
endmodule